// File: doc/BRIEF.md
# Operand Alignment Delay Bank

This block lines up operands that reach an operator at different pipeline time stamps, so that every input of that operator presents its datum in the same cycle. Each lane is a ring buffer in a small dual-port RAM. The delay of a lane is set at elaboration. It is the largest time stamp among all the lanes minus that lane's own time stamp. A lane that already carries the latest time stamp gets a delay of zero and passes its input straight through.

Every ring is addressed from one shared write pointer. The pointer moves on each cycle in which the input is valid. Each lane reads at the pointer minus its own depth, so a lane delays by a number of valid data rather than by a number of raw cycles.

Each datum carries an overflow flag that moves through the lane with it. The block also merges the flags of the aligned operands with the operator's own overflow into one flag for the operator's result. A free-running phase counter sets the global data rate of one datum every `RATE` cycles. From this counter the block raises one start pulse per sequential operator, at that operator's largest input time stamp modulo `RATE`.

Top module: `align_bank`

## Requirements
- R1: With `D(i) = max(LANE_TS) - LANE_TS[i]` and `D(i) > 0`, the `out_data` slice `[i*DATA_W +: DATA_W]` in a cycle with `in_valid` high equals the lane-i input that was presented with the D(i)-th earlier valid cycle.
- R2: A lane with `D(i) = 0` shows its current input on its output, with `out_valid[i]` high, in every cycle with `in_valid` high.
- R3: The shared write pointer advances by exactly one on each cycle with `in_valid` high and holds otherwise, so idle cycles between data do not change the alignment.
- R4: `out_valid[i]` is high only in a cycle with `in_valid` high and with at least D(i) valid data accepted since reset.
- R5: The phase counter is 0 in the first cycle after reset, rises by one each cycle and wraps from `RATE-1` to 0. `start[k]` is high exactly when the phase equals `OP_TS[k] mod RATE`, so each pulse repeats every `RATE` cycles.
- R6: `out_ovf[i]` is the overflow flag that was presented together with the datum now on lane i, and it is 0 whenever `out_valid[i]` is 0.
- R7: `op_ovf_out` is high exactly when `in_valid` is high and either `op_ovf_in` is high or some `out_ovf[i]` is high.
- R8: Reset clears the write pointer, the fill count and the phase counter. While in reset, and until enough data have been accepted afresh, the delayed lanes report invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One datum per lane is presented this cycle |
| in_data | input | NUM_LANES*DATA_W | Lane inputs, lane i at `[i*DATA_W +: DATA_W]` |
| in_ovf | input | NUM_LANES | Overflow flag per lane input, lane i at bit i |
| op_ovf_in | input | 1 | Overflow raised by the operator itself this cycle |
| out_valid | output | NUM_LANES | Aligned datum of lane i is valid |
| out_data | output | NUM_LANES*DATA_W | Aligned lane outputs, same slicing as the input |
| out_ovf | output | NUM_LANES | Overflow flag travelling with each aligned datum |
| op_ovf_out | output | 1 | Merged overflow for the operator's result |
| start | output | NUM_OPS | Periodic start pulse per sequential operator |

## Verification
The start pulses run on a free counter, and the lanes move only with valid data, so a start pulse can fall in the same cycle as a lane's first valid output, as a wrap of the write pointer, or as an idle gap. The bench runs long continuous streams that wrap the eight-entry rings, runs gapped streams whose gap pattern is out of step with the rate, and applies a reset in mid-stream. Lane outputs are judged each cycle against per-lane reference queues that are indexed by count of valid data. Start pulses are judged each cycle against a cycle count taken modulo the rate, with no dependence on the data traffic.

// File: rtl/align_pkg.sv
package align_pkg;

    // Delay of a lane: latest operand time stamp minus the lane's own.
    function automatic int delay_of(input int latest_ts, input int own_ts);
        return latest_ts - own_ts;
    endfunction

    // Cycle within the data-rate period at which an operator is started.
    function automatic int phase_of(input int ts, input int rate);
        return ts % rate;
    endfunction

    // Width needed to count 0 .. n-1, never below one bit.
    function automatic int count_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/align_addr_gen.sv
module align_addr_gen #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] fill
);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] fill;
    } gen_state_t;

    gen_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.ptr = st_q.ptr + ADDR_W'(1);
            if (st_q.fill != {ADDR_W{1'b1}}) begin
                st_d.fill = st_q.fill + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr  = st_q.ptr;
    assign fill = st_q.fill;

endmodule

// File: rtl/align_phase_gen.sv
module align_phase_gen #(
    parameter int RATE            = 3,
    parameter int NUM_OPS         = 2,
    parameter int OP_TS [NUM_OPS] = '{5, 7}
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [NUM_OPS-1:0] start
);

    localparam int CW = align_pkg::count_width(RATE);

    typedef struct packed {
        logic [CW-1:0] phase;
    } phase_state_t;

    phase_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == CW'(RATE - 1)) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        localparam int PH = align_pkg::phase_of(OP_TS[k], RATE);
        assign start[k] = (st_q.phase == CW'(PH));
    end

endmodule

// File: rtl/align_lane.sv
module align_lane #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] fill,
    input  logic [DATA_W-1:0] din,
    input  logic              din_ovf,
    output logic [DATA_W-1:0] dout,
    output logic              dout_ovf,
    output logic              dout_ready
);

    localparam int  SLOTS  = 2 ** ADDR_W;
    localparam bit  BYPASS = (DEPTH == 0);

    typedef logic [DATA_W:0] word_t;

    word_t             ring [SLOTS];
    word_t             rd_word;
    logic [ADDR_W-1:0] rd_addr;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ring[ptr] <= {din_ovf, din};
        end
    end

    always_comb begin
        rd_addr = ptr - ADDR_W'(DEPTH);
        rd_word = ring[rd_addr];
    end

    if (BYPASS) begin : g_bypass
        assign dout       = din;
        assign dout_ovf   = din_ovf;
        assign dout_ready = 1'b1;
    end else begin : g_ring
        assign dout       = rd_word[DATA_W-1:0];
        assign dout_ovf   = rd_word[DATA_W];
        assign dout_ready = (fill >= ADDR_W'(DEPTH));
    end

endmodule

// File: rtl/align_bank.sv
module align_bank #(
    parameter int NUM_LANES           = 4,
    parameter int DATA_W              = 8,
    parameter int ADDR_W              = 3,
    parameter int LANE_TS [NUM_LANES] = '{3, 0, 5, 1},
    parameter int RATE                = 3,
    parameter int NUM_OPS             = 2,
    parameter int OP_TS [NUM_OPS]     = '{5, 7}
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [NUM_LANES*DATA_W-1:0]   in_data,
    input  logic [NUM_LANES-1:0]          in_ovf,
    input  logic                          op_ovf_in,
    output logic [NUM_LANES-1:0]          out_valid,
    output logic [NUM_LANES*DATA_W-1:0]   out_data,
    output logic [NUM_LANES-1:0]          out_ovf,
    output logic                          op_ovf_out,
    output logic [NUM_OPS-1:0]            start
);

    function automatic int latest_ts();
        int m = 0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (LANE_TS[i] > m) m = LANE_TS[i];
        end
        return m;
    endfunction

    localparam int TS_MAX    = latest_ts();
    localparam int MAX_DEPTH = (2 ** ADDR_W) - 1;

    logic [ADDR_W-1:0]    ptr_w;
    logic [ADDR_W-1:0]    fill_w;
    logic [NUM_LANES-1:0] lane_ready;
    logic [NUM_LANES-1:0] lane_ovf;

    align_addr_gen #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (in_valid),
        .ptr   (ptr_w),
        .fill  (fill_w)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int D = align_pkg::delay_of(TS_MAX, LANE_TS[g]);

        if (D > MAX_DEPTH) begin : g_too_deep
            $error("lane delay exceeds ring capacity");
        end

        align_lane #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W),
            .DEPTH  (D)
        ) u_lane (
            .clk        (clk),
            .wr_en      (in_valid),
            .ptr        (ptr_w),
            .fill       (fill_w),
            .din        (in_data[g*DATA_W +: DATA_W]),
            .din_ovf    (in_ovf[g]),
            .dout       (out_data[g*DATA_W +: DATA_W]),
            .dout_ovf   (lane_ovf[g]),
            .dout_ready (lane_ready[g])
        );

        assign out_valid[g] = in_valid & lane_ready[g];
        assign out_ovf[g]   = out_valid[g] & lane_ovf[g];
    end

    assign op_ovf_out = in_valid & (op_ovf_in | (|out_ovf));

    align_phase_gen #(
        .RATE    (RATE),
        .NUM_OPS (NUM_OPS),
        .OP_TS   (OP_TS)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start)
    );

endmodule

// File: rtl/align_bank_chk.sv
module align_bank_chk #(
    parameter int NUM_LANES           = 4,
    parameter int DATA_W              = 8,
    parameter int ADDR_W              = 3,
    parameter int LANE_TS [NUM_LANES] = '{3, 0, 5, 1},
    parameter int RATE                = 3,
    parameter int NUM_OPS             = 2,
    parameter int OP_TS [NUM_OPS]     = '{5, 7}
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic [NUM_LANES*DATA_W-1:0] in_data,
    input logic [NUM_LANES-1:0]        in_ovf,
    input logic                        op_ovf_in,
    input logic [NUM_LANES-1:0]        out_valid,
    input logic [NUM_LANES*DATA_W-1:0] out_data,
    input logic [NUM_LANES-1:0]        out_ovf,
    input logic                        op_ovf_out,
    input logic [NUM_OPS-1:0]          start,
    input logic [ADDR_W-1:0]           ptr_q
);

    function automatic int latest_ts();
        int m = 0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (LANE_TS[i] > m) m = LANE_TS[i];
        end
        return m;
    endfunction

    localparam int TS_MAX = latest_ts();

    // R3: pointer moves by one per valid datum and holds otherwise
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ptr_q == $past(ptr_q) + ADDR_W'(1));
    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ptr_q == $past(ptr_q));

    // R4: no lane reports data without an input datum
    a_r4_valid_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> out_valid == '0);

    // R7: the operator's own overflow always reaches the merged flag
    a_r7_own_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_ovf_in) |-> op_ovf_out);
    a_r7_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !op_ovf_out);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane_chk
        localparam int D = align_pkg::delay_of(TS_MAX, LANE_TS[g]);

        // R6: a flag never leaves with an invalid datum
        a_r6_ovf_masked: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[g] |-> !out_ovf[g]);

        // R7: any aligned flag reaches the merged flag
        a_r7_lane_ovf: assert property (@(posedge clk) disable iff (!rst_n)
            out_ovf[g] |-> op_ovf_out);

        if (D == 0) begin : g_zero
            // R2: zero-delay lane is a straight wire
            a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> (out_valid[g] &&
                              out_data[g*DATA_W +: DATA_W] == in_data[g*DATA_W +: DATA_W] &&
                              out_ovf[g] == in_ovf[g]));
        end
    end

    // R5: start pulses fall at their phase, then every RATE cycles
    logic [15:0]        gap_q [NUM_OPS];
    logic [NUM_OPS-1:0] seen_q;

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op_chk
        localparam int PH = align_pkg::phase_of(OP_TS[k], RATE);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gap_q[k]  <= '0;
                seen_q[k] <= 1'b0;
            end else if (start[k]) begin
                gap_q[k]  <= 16'd1;
                seen_q[k] <= 1'b1;
            end else if (gap_q[k] != 16'hFFFF) begin
                gap_q[k]  <= gap_q[k] + 16'd1;
            end
        end

        a_r5_start_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            start[k] |-> gap_q[k] == (seen_q[k] ? 16'(RATE) : 16'(PH)));
    end

endmodule

bind align_bank align_bank_chk #(
    .NUM_LANES (NUM_LANES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .LANE_TS   (LANE_TS),
    .RATE      (RATE),
    .NUM_OPS   (NUM_OPS),
    .OP_TS     (OP_TS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ovf     (in_ovf),
    .op_ovf_in  (op_ovf_in),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ovf    (out_ovf),
    .op_ovf_out (op_ovf_out),
    .start      (start),
    .ptr_q      (ptr_w)
);

// File: tb/sim_align_bank.sv
`timescale 1ns/1ps
module sim_align_bank;

    localparam int NL   = 4;
    localparam int DW   = 8;
    localparam int AW   = 3;
    localparam int RATE = 3;
    localparam int NOPS = 2;
    localparam int TS  [NL]   = '{3, 0, 5, 1};
    localparam int OTS [NOPS] = '{5, 7};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [NL*DW-1:0]  in_data = '0;
    logic [NL-1:0]     in_ovf = '0;
    logic              op_ovf_in = 1'b0;
    logic [NL-1:0]     out_valid;
    logic [NL*DW-1:0]  out_data;
    logic [NL-1:0]     out_ovf;
    logic              op_ovf_out;
    logic [NOPS-1:0]   start;

    always #4 clk = ~clk;

    align_bank #(
        .NUM_LANES (NL), .DATA_W (DW), .ADDR_W (AW), .LANE_TS (TS),
        .RATE (RATE), .NUM_OPS (NOPS), .OP_TS (OTS)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
        .in_ovf (in_ovf), .op_ovf_in (op_ovf_in), .out_valid (out_valid),
        .out_data (out_data), .out_ovf (out_ovf), .op_ovf_out (op_ovf_out),
        .start (start)
    );

    typedef struct {
        logic [NL-1:0]    v;
        logic [NL*DW-1:0] d;
        logic [NL-1:0]    o;
        logic             m;
        string            tag;
    } exp_t;

    exp_t           exp_q [$];
    logic [DW:0]    hist [NL][$];
    int             dly [NL];
    int             nwr = 0;
    int             stp = 0;
    int             checks = 0;
    int             fails = 0;
    int             cyc = 0;
    bit             done = 0;

    initial begin
        int mx = 0;
        for (int i = 0; i < NL; i++) if (TS[i] > mx) mx = TS[i];
        for (int i = 0; i < NL; i++) dly[i] = mx - TS[i];
    end

    task automatic chk(input bit ok, input string req, input string tag,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (%s): actual %0h expected %0h", req, tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues what should appear.
    task automatic drive(input bit v, input bit opo, input string tag);
        exp_t e;
        logic [DW-1:0] dat [NL];
        logic          ov  [NL];
        e.v = '0; e.d = '0; e.o = '0; e.tag = tag;
        for (int l = 0; l < NL; l++) begin
            dat[l] = DW'(l * 37 + stp * 13 + 5);
            ov[l]  = ((stp + l) % 5 == 0);
            in_data[l*DW +: DW] = dat[l];
            in_ovf[l] = ov[l];
        end
        in_valid  = v;
        op_ovf_in = opo;
        if (v) begin
            for (int l = 0; l < NL; l++) begin
                if (dly[l] == 0) begin
                    e.v[l] = 1'b1; e.d[l*DW +: DW] = dat[l]; e.o[l] = ov[l];
                end else if (nwr >= dly[l]) begin
                    e.v[l] = 1'b1;
                    e.d[l*DW +: DW] = hist[l][dly[l]-1][DW-1:0];
                    e.o[l] = hist[l][dly[l]-1][DW];
                end
            end
            for (int l = 0; l < NL; l++) begin
                hist[l].push_front({ov[l], dat[l]});
                if (hist[l].size() > 16) void'(hist[l].pop_back());
            end
            nwr++;
        end
        e.m = v & (opo | (|(e.v & e.o)));
        stp++;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: pops each expectation and compares it with the ports.
    initial forever begin
        @(negedge clk);
        #3;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            for (int l = 0; l < NL; l++) begin
                chk(out_valid[l] == e.v[l], "R4 lane valid", e.tag, out_valid[l], e.v[l]);
                if (e.v[l]) begin
                    chk(out_data[l*DW +: DW] == e.d[l*DW +: DW],
                        (dly[l] == 0) ? "R2 passthrough data" : "R1 delayed data",
                        e.tag, out_data[l*DW +: DW], e.d[l*DW +: DW]);
                end
                chk(out_ovf[l] == e.o[l], "R6 lane overflow", e.tag, out_ovf[l], e.o[l]);
            end
            chk(op_ovf_out == e.m, "R7 merged overflow", e.tag, op_ovf_out, e.m);
        end
    end

    // Start pulse monitor, independent of traffic.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    initial forever begin
        @(negedge clk);
        #3;
        if (rst_n) begin
            for (int k = 0; k < NOPS; k++) begin
                bit want;
                want = ((cyc % RATE) == (OTS[k] % RATE));
                chk(start[k] == want, "R5 start phase", "free run", start[k], want);
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        op_ovf_in = 1'b0;
        nwr = 0;
        for (int l = 0; l < NL; l++) hist[l].delete();
        repeat (3) @(negedge clk);
        #3;
        chk(out_valid == '0, "R8 valid in reset", "reset", out_valid, 0);
        chk(op_ovf_out == 1'b0, "R8 overflow in reset", "reset", op_ovf_out, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        for (int i = 0; i < 20; i++) drive(1'b1, (i % 7) == 3, "R1 stream");
        for (int i = 0; i < 4; i++)  drive(1'b0, 1'b1, "R3 idle");
        for (int i = 0; i < 24; i++) drive((i % 3) != 0, (i % 5) == 1, "R3 gaps");
        for (int i = 0; i < 6; i++)  drive(1'b1, 1'b1, "R7 own overflow");
        for (int i = 0; i < 5; i++)  drive(1'b1, 1'b0, "R8 pre-reset");
        do_reset();
        for (int i = 0; i < 14; i++) drive(1'b1, 1'b0, "R8 refill");
        for (int i = 0; i < 10; i++) drive((i % 2) == 0, 1'b0, "R3 alternate");
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule